// File: doc/BRIEF.md
# DMA Channel Interrupt and Timeout Unit

This unit sits beside the transfer engine of one DMA channel and turns the engine's single-cycle event pulses into sticky status flags. The five events are a bus error response, transfer completion, remaining count reaching zero, remaining count reaching half of the programmed count, and a peripheral timeout. Software programs which flags may raise the channel's single interrupt line, reads the flags, and clears them by writing ones.

The timeout event comes from an internal countdown timer. While the channel's timeout enable input is high, the timer counts down from a software-programmed 16-bit reload value. Each fully serviced peripheral request restarts it from that value. If it reaches zero before the next service, the peripheral is considered stalled and the timeout flag is raised. The timer then waits at zero until it is restarted.

The timer is a three-state machine. OFF means the timeout enable is low and the count is zero. RUN means counting. EXPIRED means the count has run out. The transitions are as follows:
- OFF goes to RUN when the enable rises, and the reload value is loaded.
- RUN stays in RUN when a request is serviced, and the count is reloaded.
- RUN goes to EXPIRED when the count is zero and no request is serviced; this fires the timeout event.
- EXPIRED goes to RUN when a request is serviced, and the count is reloaded.
- Any state goes to OFF when the enable falls.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the enable, status and reload registers read zero and `irq` is low.
- R2: The enable and status registers share one layout. Bit 0 is bus error, bit 1 is transfer done, bit 2 is count-zero (wrap field value 1), bit 4 is half-count (wrap field value 4) and bit 6 is timeout. Bits 3, 5 and 7 and up always read 0, whatever is written.
- R3: An event pulse sets its status bit at the next rising clock edge, and the bit stays set until software clears it.
- R4: Writing 1 to a status bit clears it at the next edge. Writing 0 to a status bit leaves it unchanged.
- R5: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is high exactly when some status bit and its matching enable bit are both 1. It follows the registered flags with no extra delay.
- R7: When `tmo_enable` is sampled high in OFF, the counter loads the reload value R at that edge (the load edge). It then decrements once per cycle. The timeout status bit is set at the (R+1)-th edge after the load edge, including for R = 0.
- R8: A serviced-request pulse while the timer is running or expired reloads the counter with R. The timeout bit is then set R+1 edges after that reload edge, unless another service arrives first.
- R9: After a timeout the counter holds at zero and raises no further timeout until it is reloaded. When `tmo_enable` is low the timer stays off and never sets the timeout bit.
- R10: The reload register is readable and writable over the full 16 bits. Register select 0 addresses the enable register, 1 the status register, 2 the reload register, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_enable | input | 1 | Timeout counter enable from the channel control word |
| ev_bus_err | input | 1 | Pulse: bus master received an error response |
| ev_done | input | 1 | Pulse: transfer complete |
| ev_cnt_zero | input | 1 | Pulse: remaining count reached zero |
| ev_cnt_half | input | 1 | Pulse: remaining count reached half the programmed count |
| ev_req_served | input | 1 | Pulse: one peripheral request fully serviced |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 reload |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq | output | 1 | Channel interrupt request |

## Verification
Event pulses and register writes take effect at the first rising edge that samples them. The status bits and `irq` are therefore due one edge after the stimulus, and the bench drives at falling edges and reads at the following falling edge. For a reload value R, the timeout bit is due exactly R+1 edges after the load or reload edge. The bench checks it is still clear after R edges and set after R+1, sweeping R from 0 upward. All 32 enable masks are swept against every direct event, and the expected status and `irq` values are computed from the bit layout.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    // Dense flag order used inside the unit
    localparam int N_FLAGS  = 5;
    localparam int F_ABORT  = 0;
    localparam int F_DONE   = 1;
    localparam int F_ZERO   = 2;
    localparam int F_HALF   = 3;
    localparam int F_TOUT   = 4;

    // Register layout positions (decoded by software)
    localparam int LAY_W      = 7;
    localparam int POS_ABORT  = 0;
    localparam int POS_DONE   = 1;
    localparam int POS_ZERO   = 2;
    localparam int POS_HALF   = 4;
    localparam int POS_TOUT   = 6;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TMR_OFF     = 2'd0,
        TMR_RUN     = 2'd1,
        TMR_EXPIRED = 2'd2
    } tmr_state_e;

    function automatic logic [LAY_W-1:0] spread(input logic [N_FLAGS-1:0] d);
        logic [LAY_W-1:0] r;
        r            = '0;
        r[POS_ABORT] = d[F_ABORT];
        r[POS_DONE]  = d[F_DONE];
        r[POS_ZERO]  = d[F_ZERO];
        r[POS_HALF]  = d[F_HALF];
        r[POS_TOUT]  = d[F_TOUT];
        return r;
    endfunction

    function automatic logic [N_FLAGS-1:0] gather(input logic [LAY_W-1:0] w);
        logic [N_FLAGS-1:0] r;
        r[F_ABORT] = w[POS_ABORT];
        r[F_DONE]  = w[POS_DONE];
        r[F_ZERO]  = w[POS_ZERO];
        r[F_HALF]  = w[POS_HALF];
        r[F_TOUT]  = w[POS_TOUT];
        return r;
    endfunction

endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
    import dma_irq_pkg::*;
#(
    parameter int N = N_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);

    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]); // R5
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]); // R4
        AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_vec[i]) |=> flag_q[i]); // R3
    end

    assign flags = flag_q;

endmodule

// File: rtl/dma_irq_timer.sv
module dma_irq_timer
    import dma_irq_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             served,
    input  logic [TMR_W-1:0] reload,
    output logic             fire
);

    tmr_state_e       state_q, state_d;
    logic [TMR_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_OFF: begin
                cnt_d = '0;
                if (run_en) begin
                    state_d = TMR_RUN;
                    cnt_d   = reload;
                end
            end
            TMR_RUN: begin
                if (!run_en) begin
                    state_d = TMR_OFF;
                    cnt_d   = '0;
                end else if (served) begin
                    cnt_d = reload;
                end else if (cnt_zero) begin
                    state_d = TMR_EXPIRED;
                end else begin
                    cnt_d = cnt_q - TMR_W'(1);
                end
            end
            TMR_EXPIRED: begin
                if (!run_en) begin
                    state_d = TMR_OFF;
                    cnt_d   = '0;
                end else if (served) begin
                    state_d = TMR_RUN;
                    cnt_d   = reload;
                end
            end
            default: begin
                state_d = TMR_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            TMR_RUN:     fire = run_en && !served && cnt_zero;
            TMR_OFF,
            TMR_EXPIRED: fire = 1'b0;
            default:     fire = 1'b0;
        endcase
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_RUN && run_en && !served && !cnt_zero)
        |=> (cnt_q == $past(cnt_q) - TMR_W'(1))); // R7
    AST_RELOAD_ON_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TMR_OFF && run_en && served)
        |=> (state_q == TMR_RUN && cnt_q == $past(reload))); // R8
    AST_HOLD_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TMR_EXPIRED && run_en && !served)
        |=> (state_q == TMR_EXPIRED && cnt_q == '0)); // R9
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == TMR_OFF && !fire)); // R9

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_irq_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmo_enable,
    input  logic             ev_bus_err,
    input  logic             ev_done,
    input  logic             ev_cnt_zero,
    input  logic             ev_cnt_half,
    input  logic             ev_req_served,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [TMR_W-1:0] reg_wdata,
    output logic [TMR_W-1:0] reg_rdata,
    output logic             irq
);

    localparam int PAD_W = TMR_W - LAY_W;

    reg_sel_e             sel;
    logic                 en_wr, status_wr, reload_wr;
    logic [N_FLAGS-1:0]   en_q;
    logic [TMR_W-1:0]     reload_q;
    logic [N_FLAGS-1:0]   set_dense, clr_dense, status;
    logic                 tmo_fire;

    assign sel       = reg_sel_e'(reg_sel);
    assign en_wr     = reg_wr && (sel == SEL_ENABLE);
    assign status_wr = reg_wr && (sel == SEL_STATUS);
    assign reload_wr = reg_wr && (sel == SEL_RELOAD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            reload_q <= '0;
        end else begin
            if (en_wr) begin
                en_q <= gather(reg_wdata[LAY_W-1:0]);
            end
            if (reload_wr) begin
                reload_q <= reg_wdata;
            end
        end
    end

    dma_irq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (tmo_enable),
        .served (ev_req_served),
        .reload (reload_q),
        .fire   (tmo_fire)
    );

    always_comb begin
        set_dense          = '0;
        set_dense[F_ABORT] = ev_bus_err;
        set_dense[F_DONE]  = ev_done;
        set_dense[F_ZERO]  = ev_cnt_zero;
        set_dense[F_HALF]  = ev_cnt_half;
        set_dense[F_TOUT]  = tmo_fire;
    end

    assign clr_dense = status_wr ? gather(reg_wdata[LAY_W-1:0]) : '0;

    dma_irq_flags #(.N(N_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_dense),
        .clr_vec (clr_dense),
        .flags   (status)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_ENABLE: reg_rdata = {{PAD_W{1'b0}}, spread(en_q)};
            SEL_STATUS: reg_rdata = {{PAD_W{1'b0}}, spread(status)};
            SEL_RELOAD: reg_rdata = reload_q;
            SEL_NONE:   reg_rdata = '0;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |(status & en_q);

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|set_dense) || $past(en_wr))); // R6
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(status_wr) || $past(en_wr))); // R4
    AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q)); // R10

endmodule

// File: tb/dma_irq_unit_test.sv
`timescale 1ns/1ps
module dma_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmo_enable = 1'b0;
    logic        ev_bus_err = 1'b0, ev_done = 1'b0, ev_cnt_zero = 1'b0, ev_cnt_half = 1'b0;
    logic        ev_req_served = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .tmo_enable(tmo_enable),
        .ev_bus_err(ev_bus_err), .ev_done(ev_done), .ev_cnt_zero(ev_cnt_zero),
        .ev_cnt_half(ev_cnt_half), .ev_req_served(ev_req_served),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    localparam logic [15:0] BIT_TOUT = 16'h0040;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input int idx);
        case (idx)
            0: ev_bus_err = 1'b1;
            1: ev_done = 1'b1;
            2: ev_cnt_zero = 1'b1;
            default: ev_cnt_half = 1'b1;
        endcase
        @(negedge clk);
        ev_bus_err = 1'b0; ev_done = 1'b0; ev_cnt_zero = 1'b0; ev_cnt_half = 1'b0;
    endtask

    function automatic logic [15:0] ev_bit(input int idx);
        case (idx)
            0: return 16'h0001;
            1: return 16'h0002;
            2: return 16'h0004;
            default: return 16'h0010;
        endcase
    endfunction

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [15:0] v, en;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v == 0, "R1 enable reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R1 status reset", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 reload reset", v, 0);
        chk(irq == 0, "R1 irq reset", 16'(irq), 0);

        // R2 reserved bits, R10 register access
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); chk(v == 16'h0057, "R2 enable layout", v, 16'h0057);
        wr(2'd2, 16'hA5C3);
        rd(2'd2, v); chk(v == 16'hA5C3, "R10 reload rw", v, 16'hA5C3);
        rd(2'd3, v); chk(v == 16'h0000, "R10 unused select", v, 0);
        wr(2'd0, 16'h0000);
        rd(2'd0, v); chk(v == 0, "R10 enable rw", v, 0);

        // R2 R3 R4 R6: sweep all enable masks against every direct event
        for (int m = 0; m < 32; m++) begin
            en = {9'd0, m[4], 1'b0, m[3], 1'b0, m[2], m[1], m[0]};
            wr(2'd0, en);
            for (int i = 0; i < 4; i++) begin
                pulse(i);
                rd(2'd1, v); chk(v == ev_bit(i), "R3 event sets status", v, ev_bit(i));
                chk(irq == ((en & ev_bit(i)) != 0), "R6 irq mask", 16'(irq), 16'((en & ev_bit(i)) != 0));
                @(negedge clk);
                rd(2'd1, v); chk(v == ev_bit(i), "R3 status sticky", v, ev_bit(i));
                wr(2'd1, 16'hFFFF);
                rd(2'd1, v); chk(v == 0, "R4 w1c clears", v, 0);
                chk(irq == 0, "R6 irq after clear", 16'(irq), 0);
            end
        end

        // R4 write zero has no effect; R2 reserved status bits
        pulse(0); pulse(2);
        wr(2'd1, 16'h0000);
        rd(2'd1, v); chk(v == 16'h0005, "R4 write zero keeps", v, 16'h0005);
        wr(2'd1, 16'h0001);
        rd(2'd1, v); chk(v == 16'h0004, "R4 partial clear", v, 16'h0004);
        wr(2'd1, 16'hFFFF);

        // R5 set wins over clear in the same cycle
        pulse(1);
        ev_done = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0002; reg_wr = 1'b1;
        @(negedge clk);
        ev_done = 1'b0; reg_wr = 1'b0;
        rd(2'd1, v); chk(v == 16'h0002, "R5 set wins (already set)", v, 16'h0002);
        wr(2'd1, 16'hFFFF);
        ev_cnt_half = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0010; reg_wr = 1'b1;
        @(negedge clk);
        ev_cnt_half = 1'b0; reg_wr = 1'b0;
        rd(2'd1, v); chk(v == 16'h0010, "R5 set wins (was clear)", v, 16'h0010);
        wr(2'd1, 16'hFFFF);

        // R7 R9: timeout timing sweep over reload values
        wr(2'd0, BIT_TOUT);
        for (int r = 0; r < 8; r++) begin
            wr(2'd2, 16'(r));
            tmo_enable = 1'b1;
            @(negedge clk);                 // load edge
            repeat (r) @(negedge clk);
            rd(2'd1, v); chk(v == 0, "R7 no timeout before R+1", v, 0);
            @(negedge clk);
            rd(2'd1, v); chk(v == BIT_TOUT, "R7 timeout at R+1", v, BIT_TOUT);
            chk(irq == 1, "R6 timeout irq", 16'(irq), 1);
            wr(2'd1, BIT_TOUT);
            repeat (r + 3) @(negedge clk);
            rd(2'd1, v); chk(v == 0, "R9 holds after timeout", v, 0);
            tmo_enable = 1'b0;
            @(negedge clk);
        end

        // R8: serve while running reloads
        wr(2'd2, 16'd4);
        tmo_enable = 1'b1;
        @(negedge clk);                     // load edge
        @(negedge clk);
        ev_req_served = 1'b1;
        @(negedge clk);                     // reload edge
        ev_req_served = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk(v == 0, "R8 served delays timeout", v, 0);
        @(negedge clk);
        rd(2'd1, v); chk(v == BIT_TOUT, "R8 timeout after reload", v, BIT_TOUT);
        wr(2'd1, BIT_TOUT);

        // R8 R9: serve while expired restarts the count
        ev_req_served = 1'b1;
        @(negedge clk);
        ev_req_served = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd1, v); chk(v == 0, "R9 restart no early timeout", v, 0);
        @(negedge clk);
        rd(2'd1, v); chk(v == BIT_TOUT, "R8 restart from expired", v, BIT_TOUT);
        wr(2'd1, BIT_TOUT);
        tmo_enable = 1'b0;
        @(negedge clk);

        // R9: disabled timer never times out
        wr(2'd2, 16'd6);
        tmo_enable = 1'b1;
        repeat (3) @(negedge clk);
        tmo_enable = 1'b0;
        repeat (12) @(negedge clk);
        rd(2'd1, v); chk(v == 0, "R9 disabled no timeout", v, 0);
        chk(irq == 0, "R9 irq stays low", 16'(irq), 0);

        finish_sim();
    end

endmodule